// File: doc/BRIEF.md
# Cascadable Output Summer and Formatter

This block takes the I and Q sample streams of a group of modulator channels and forms the samples placed on the output buses. Each output sample is 20-bit two's complement with bit 19 as the MSB, and all outputs are registered. Sums that leave the 20-bit range are clamped to the nearest limit. There are four output buses. Buses A and B always drive pins. Buses C and D are bidirectional pads, represented here as an input side, an output side and a shared output enable.

In cascade mode the pads of buses C and D become inputs. They carry the I and Q results of an upstream device, which are that device's buses A and B. The two pad samples are captured on the same edge as the channel samples and added into the I sum (bus A) and the Q sum (bus B). This lets any number of devices be chained.

In the other modes buses C and D are outputs:
- Split mode gives each half of the channel group its own bus pair.
- Full mode mirrors the whole-group sums onto both bus pairs.
- Muxed mode interleaves the whole-group I and Q sums on every bus, one per cycle. It raises a strobe in the cycles that carry I.

Top module: `out_summer_fmt`

## Requirements
- R1: While rst_ni is low, all four output buses read 0 and i_strb_o is 0. The muxed-mode phase returns to the I slot.
- R2: Channel k occupies bits [k*20+19 : k*20] of the channel input vectors. Samples are captured on a rising edge and appear at the outputs after that same edge. In split mode (mode_i = 0), bus A carries the I sum of channels 0..1 and bus B the Q sum of channels 0..1. Bus C carries the I sum of channels 2..3 and bus D the Q sum of channels 2..3.
- R3: Every bus value saturates to the range -524288..524287 instead of wrapping. A sum of exactly 524287 passes unchanged.
- R4: In cascade mode (mode_i = 1), bus A carries the I sum of all channels plus the value on aux_i_i. Bus B carries the Q sum of all channels plus the value on aux_q_i. Both pad values are captured on the same edge as the channel samples.
- R5: aux_oe_o is 0 whenever mode_i is 1 and 1 for every other mode. In cascade mode the output sides aux_i_o and aux_q_o read 0.
- R6: In full mode (mode_i = 3), buses A and C carry the whole-group I sum and buses B and D carry the whole-group Q sum.
- R7: In muxed mode (mode_i = 2), all four buses carry the same value. The value alternates between the whole-group I sum and Q sum on successive cycles. The first cycle after reset, or after entering the mode, carries I. i_strb_o is 1 exactly in the cycles that carry I.
- R8: i_strb_o is 0 in every mode other than muxed.
- R9: aux_i_i and aux_q_i have no effect on any bus outside cascade mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 split, 1 cascade, 2 muxed, 3 full |
| ch_i_i | input | 80 | I samples of the channel group, channel 0 in the low bits |
| ch_q_i | input | 80 | Q samples of the channel group |
| aux_i_i | input | 20 | Input side of pad bus C (upstream I in cascade) |
| aux_q_i | input | 20 | Input side of pad bus D (upstream Q in cascade) |
| out_a_o | output | 20 | Bus A |
| out_b_o | output | 20 | Bus B |
| aux_i_o | output | 20 | Output side of pad bus C |
| aux_q_o | output | 20 | Output side of pad bus D |
| aux_oe_o | output | 1 | Output enable for pad buses C and D |
| i_strb_o | output | 1 | High while the buses carry I in muxed mode |

## Verification
Split mode is driven with small mixed-sign values so that a swap of the channel halves, or of I with Q, gives a visibly wrong bus. Sums just at and just past both 20-bit limits separate saturation from wrapping and from an off-by-one clamp. Cascade inputs are driven with values of opposite sign on the two pads, once in cascade mode and once in non-cascade modes; this shows whether the pads are added only where they should be and on the right path. Muxed mode runs with inputs that change every cycle, and is then left and re-entered, so that both the I/Q order and its restart on re-entry are visible.

// File: rtl/ose_pkg.sv
package ose_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_CASC  = 2'd1,
    MODE_MUX   = 2'd2,
    MODE_FULL  = 2'd3
  } ose_mode_e;
endpackage

// File: rtl/ose_lane_sum.sv
module ose_lane_sum #(
  parameter int N  = 2,
  parameter int W  = 20,
  parameter int SW = 24
) (
  input  logic [N*W-1:0]         d_i,
  output logic signed [SW-1:0]   s_o
);
  logic signed [SW-1:0] ext [N];

  for (genvar k = 0; k < N; k++) begin : g_ext
    assign ext[k] = {{(SW-W){d_i[k*W+W-1]}}, d_i[k*W +: W]};
  end

  always_comb begin
    s_o = '0;
    for (int k = 0; k < N; k++) s_o = s_o + ext[k];
  end
endmodule

// File: rtl/ose_sat.sv
module ose_sat #(
  parameter int IW = 24,
  parameter int OW = 20
) (
  input  logic signed [IW-1:0] d_i,
  output logic [OW-1:0]        q_o
);
  localparam logic signed [IW-1:0] MAXV = IW'((64'sd1 <<< (OW-1)) - 64'sd1);
  localparam logic signed [IW-1:0] MINV = -MAXV - IW'(1);

  always_comb begin
    if (d_i > MAXV)      q_o = MAXV[OW-1:0];
    else if (d_i < MINV) q_o = MINV[OW-1:0];
    else                 q_o = d_i[OW-1:0];
  end
endmodule

// File: rtl/ose_phase.sv
// Muxed-mode slot: 0 = I, 1 = Q; parked at I outside the mode.
module ose_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic ph_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_o <= 1'b0;
    else if (run_i)  ph_o <= ~ph_o;
    else             ph_o <= 1'b0;
  end
endmodule

// File: rtl/out_summer_fmt.sv
module out_summer_fmt
  import ose_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int W    = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [N_CH*W-1:0] ch_i_i,
  input  logic [N_CH*W-1:0] ch_q_i,
  input  logic [W-1:0]      aux_i_i,
  input  logic [W-1:0]      aux_q_i,
  output logic [W-1:0]      out_a_o,
  output logic [W-1:0]      out_b_o,
  output logic [W-1:0]      aux_i_o,
  output logic [W-1:0]      aux_q_o,
  output logic              aux_oe_o,
  output logic              i_strb_o
);
  localparam int LO = N_CH / 2;
  localparam int HI = N_CH - LO;
  localparam int SW = W + $clog2(N_CH + 1) + 1;

  ose_mode_e mode;
  assign mode = ose_mode_e'(mode_i);

  logic              casc;
  assign casc = (mode == MODE_CASC);

  // path 0 = I, path 1 = Q
  logic [N_CH*W-1:0]    ch   [2];
  logic [W-1:0]         aux  [2];
  logic signed [SW-1:0] lo_s [2];
  logic signed [SW-1:0] hi_s [2];
  logic signed [SW-1:0] fu_s [2];
  logic [W-1:0]         lo_q [2];
  logic [W-1:0]         hi_q [2];
  logic [W-1:0]         fu_q [2];

  assign ch[0]  = ch_i_i;
  assign ch[1]  = ch_q_i;
  assign aux[0] = aux_i_i;
  assign aux[1] = aux_q_i;

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic signed [SW-1:0] cas_s;

    ose_lane_sum #(.N(LO), .W(W), .SW(SW)) u_lo (
      .d_i(ch[p][LO*W-1:0]), .s_o(lo_s[p]));
    ose_lane_sum #(.N(HI), .W(W), .SW(SW)) u_hi (
      .d_i(ch[p][N_CH*W-1:LO*W]), .s_o(hi_s[p]));

    assign cas_s   = casc ? {{(SW-W){aux[p][W-1]}}, aux[p]} : '0;
    assign fu_s[p] = lo_s[p] + hi_s[p] + cas_s;

    ose_sat #(.IW(SW), .OW(W)) u_sat_lo (.d_i(lo_s[p]), .q_o(lo_q[p]));
    ose_sat #(.IW(SW), .OW(W)) u_sat_hi (.d_i(hi_s[p]), .q_o(hi_q[p]));
    ose_sat #(.IW(SW), .OW(W)) u_sat_fu (.d_i(fu_s[p]), .q_o(fu_q[p]));
  end

  logic ph;
  ose_phase u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (mode == MODE_MUX),
    .ph_o  (ph)
  );

  logic [W-1:0] a_d, b_d, c_d, d_d, mx;
  logic         strb_d;

  assign mx = ph ? fu_q[1] : fu_q[0];

  always_comb begin
    a_d = fu_q[0];
    b_d = fu_q[1];
    c_d = fu_q[0];
    d_d = fu_q[1];
    strb_d = 1'b0;
    unique case (mode)
      MODE_SPLIT: begin
        a_d = lo_q[0]; b_d = lo_q[1]; c_d = hi_q[0]; d_d = hi_q[1];
      end
      MODE_CASC: begin
        c_d = '0; d_d = '0;
      end
      MODE_MUX: begin
        a_d = mx; b_d = mx; c_d = mx; d_d = mx;
        strb_d = ~ph;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_a_o  <= '0;
      out_b_o  <= '0;
      aux_i_o  <= '0;
      aux_q_o  <= '0;
      i_strb_o <= 1'b0;
    end else begin
      out_a_o  <= a_d;
      out_b_o  <= b_d;
      aux_i_o  <= c_d;
      aux_q_o  <= d_d;
      i_strb_o <= strb_d;
    end
  end

  // pads turn around with the mode so an upstream driver never contends
  assign aux_oe_o = ~casc;
endmodule

// File: rtl/ose_chk.sv
module ose_chk #(
  parameter int W = 20
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   mode_i,
  input logic [W-1:0] out_a_o,
  input logic [W-1:0] out_b_o,
  input logic [W-1:0] aux_i_o,
  input logic [W-1:0] aux_q_o,
  input logic         aux_oe_o,
  input logic         i_strb_o
);
  logic [1:0] vcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vcnt <= 2'd0;
    else if (vcnt != 2'd2) vcnt <= vcnt + 2'd1;
  end

  a_r5_oe_casc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |-> !aux_oe_o);

  a_r5_oe_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd1) |-> aux_oe_o);

  a_r5_cd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcnt != 2'd0 && $past(mode_i) == 2'd1) |-> (aux_i_o == '0 && aux_q_o == '0));

  a_r8_strb_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcnt != 2'd0 && $past(mode_i) != 2'd2) |-> !i_strb_o);

  a_r7_first_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcnt == 2'd2 && $past(mode_i) == 2'd2 && $past(mode_i, 2) != 2'd2) |-> i_strb_o);

  a_r7_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcnt == 2'd2 && $past(mode_i) == 2'd2 && $past(mode_i, 2) == 2'd2)
      |-> (i_strb_o != $past(i_strb_o)));

  a_r7_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcnt != 2'd0 && $past(mode_i) == 2'd2)
      |-> (out_b_o == out_a_o && aux_i_o == out_a_o && aux_q_o == out_a_o));
endmodule

bind out_summer_fmt ose_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .out_a_o (out_a_o),
  .out_b_o (out_b_o),
  .aux_i_o (aux_i_o),
  .aux_q_o (aux_q_o),
  .aux_oe_o(aux_oe_o),
  .i_strb_o(i_strb_o)
);

// File: tb/out_summer_fmt_tb.sv
`timescale 1ns/1ps
module out_summer_fmt_tb;
  localparam int N_CH = 4;
  localparam int W    = 20;
  localparam int MAXV = 524287;
  localparam int MINV = -524288;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        mode_i = 2'd0;
  logic [N_CH*W-1:0] ch_i_i = '0;
  logic [N_CH*W-1:0] ch_q_i = '0;
  logic [W-1:0]      aux_i_i = '0;
  logic [W-1:0]      aux_q_i = '0;
  logic [W-1:0]      out_a_o, out_b_o, aux_i_o, aux_q_o;
  logic              aux_oe_o, i_strb_o;

  always #10 clk_i = ~clk_i;

  out_summer_fmt #(.N_CH(N_CH), .W(W)) u_dut (.*);

  typedef struct {
    int    a, b, c, d;
    bit    s, oe;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   ph    = 1'b0;
  bit   done  = 1'b0;

  function automatic int sat(input int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  // driver: apply one cycle of stimulus and queue what the next edge must produce
  task automatic drive(input logic [1:0] m, input int ci[4], input int cq[4],
                       input int ai, input int aq, input string tag);
    exp_t e;
    int lo_i, hi_i, lo_q, hi_q, fu_i, fu_q;
    @(negedge clk_i);
    mode_i = m;
    for (int k = 0; k < N_CH; k++) begin
      ch_i_i[k*W +: W] = ci[k][W-1:0];
      ch_q_i[k*W +: W] = cq[k][W-1:0];
    end
    aux_i_i = ai[W-1:0];
    aux_q_i = aq[W-1:0];
    lo_i = ci[0] + ci[1]; hi_i = ci[2] + ci[3];
    lo_q = cq[0] + cq[1]; hi_q = cq[2] + cq[3];
    fu_i = lo_i + hi_i + ((m == 2'd1) ? ai : 0);
    fu_q = lo_q + hi_q + ((m == 2'd1) ? aq : 0);
    e.tag = tag; e.s = 1'b0; e.oe = (m != 2'd1);
    case (m)
      2'd0: begin e.a = sat(lo_i); e.b = sat(lo_q); e.c = sat(hi_i); e.d = sat(hi_q); end
      2'd1: begin e.a = sat(fu_i); e.b = sat(fu_q); e.c = 0; e.d = 0; end
      2'd2: begin
        e.a = ph ? sat(fu_q) : sat(fu_i);
        e.b = e.a; e.c = e.a; e.d = e.a;
        e.s = ~ph;
      end
      default: begin e.a = sat(fu_i); e.b = sat(fu_q); e.c = sat(fu_i); e.d = sat(fu_q); end
    endcase
    ph = (m == 2'd2) ? ~ph : 1'b0;
    exp_q.push_back(e);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (sx(out_a_o) != e.a || sx(out_b_o) != e.b || sx(aux_i_o) != e.c ||
            sx(aux_q_o) != e.d || i_strb_o != e.s || aux_oe_o != e.oe) begin
          bad++;
          $display("FAIL %s: a=%0d b=%0d c=%0d d=%0d s=%0b oe=%0b exp a=%0d b=%0d c=%0d d=%0d s=%0b oe=%0b",
                   e.tag, sx(out_a_o), sx(out_b_o), sx(aux_i_o), sx(aux_q_o), i_strb_o, aux_oe_o,
                   e.a, e.b, e.c, e.d, e.s, e.oe);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state with busy inputs
    mode_i = 2'd2;
    ch_i_i = {4{20'd1234}};
    ch_q_i = {4{20'd777}};
    repeat (3) @(posedge clk_i);
    #2;
    total++;
    if (out_a_o != '0 || out_b_o != '0 || aux_i_o != '0 || aux_q_o != '0 || i_strb_o != 1'b0) begin
      bad++;
      $display("FAIL R1: a=%0d b=%0d c=%0d d=%0d s=%0b exp all 0",
               sx(out_a_o), sx(out_b_o), sx(aux_i_o), sx(aux_q_o), i_strb_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    ph = 1'b0;

    // R2: split mode
    drive(2'd0, '{1, 2, 3, 4}, '{10, 20, 30, 40}, 0, 0, "R2 small");
    drive(2'd0, '{-5, 2, 100, -300}, '{-1, -1, 7, 0}, 0, 0, "R2 mixed sign");
    drive(2'd0, '{-100000, -2000, 50000, 6}, '{12345, -54321, -1, 1}, 0, 0, "R2 wide");
    // R3: saturation limits
    drive(2'd0, '{262144, 262143, -262144, -262144}, '{524287, 0, -524288, 0}, 0, 0, "R3 exact limits");
    drive(2'd0, '{262144, 262144, -262144, -262145}, '{300000, 300000, -300000, -300000}, 0, 0, "R3 clamp");
    drive(2'd3, '{400000, 400000, 400000, 400000}, '{-400000, -400000, -400000, -400000}, 0, 0, "R3 full clamp");
    // R6: full mode
    drive(2'd3, '{1, 2, 3, 4}, '{-10, 20, -30, 40}, 0, 0, "R6 full");
    // R9: pads ignored outside cascade
    drive(2'd0, '{1, 2, 3, 4}, '{5, 6, 7, 8}, 400000, -400000, "R9 split pads");
    drive(2'd3, '{1, 2, 3, 4}, '{5, 6, 7, 8}, 400000, -400000, "R9 full pads");
    // R4/R5: cascade
    drive(2'd1, '{1, 2, 3, 4}, '{5, 6, 7, 8}, 1000, -2000, "R4 cascade sum");
    drive(2'd1, '{-10, 0, 0, 0}, '{0, 0, 0, 30}, -7, 11, "R4 cascade small");
    drive(2'd1, '{200000, 200000, 0, 0}, '{-200000, -200000, 0, 0}, 200000, -200000, "R4 cascade clamp");
    drive(2'd1, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 3, -4, "R5 cascade oe and idle pads");
    // R7: muxed
    drive(2'd2, '{1, 2, 3, 4}, '{10, 20, 30, 40}, 999, 999, "R7 mux first I");
    drive(2'd2, '{5, 5, 5, 5}, '{-1, -2, -3, -4}, 0, 0, "R7 mux Q");
    drive(2'd2, '{7, 0, 0, 0}, '{8, 0, 0, 0}, 0, 0, "R7 mux I");
    drive(2'd2, '{7, 0, 0, 0}, '{300000, 300000, 0, 0}, 0, 0, "R7 mux Q clamp");
    drive(2'd2, '{-9, 0, 0, 0}, '{9, 0, 0, 0}, 0, 0, "R7 mux I again");
    // R8: strobe low after leaving, then R7 restart on I
    drive(2'd0, '{1, 1, 1, 1}, '{2, 2, 2, 2}, 0, 0, "R8 split strobe low");
    drive(2'd3, '{1, 1, 1, 1}, '{2, 2, 2, 2}, 0, 0, "R8 full strobe low");
    drive(2'd2, '{3, 3, 3, 3}, '{-6, 0, 0, 0}, 0, 0, "R7 re-entry starts I");
    drive(2'd2, '{3, 3, 3, 3}, '{-6, 0, 0, 0}, 0, 0, "R7 re-entry Q");
    drive(2'd0, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 0, 0, "R8 idle");

    while (exp_q.size() > 0) @(posedge clk_i);
    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule